// File: doc/BRIEF.md
# Sub-Word Register Access Adapter

This block connects a byte-addressed port, which may issue 1-, 2- or 4-byte accesses at any byte offset, to register banks that are only ever read and written as whole 32-bit words. A 128-byte window is split into three target regions: a bank of SCSI core registers, a bank of DMA channel registers and one bus-and-control word. Each bank appears as a combinational word read port and a registered word write strobe.

A write narrower than a word, or one that starts off a word boundary, becomes a read-modify-write. The block reads the target word and replaces only the addressed byte lanes. It then issues one full-word write in the following cycle. A read returns the addressed word shifted down to its byte lane and masked to the access width. A write that follows directly behind another write to the same word must see that earlier update. For this reason the pending write is forwarded into the merge.

Top module: `subword_reg_adapter`

## Requirements
- R1: Offsets 0x00–0x3F select core word `offset>>2`. Offsets 0x40–0x5F select DMA word `(offset-0x40)>>2`. Offsets 0x70–0x73 select the single control word.
- R2: An access to 0x60–0x6F or 0x74–0x7F is unmapped. A write there produces no bank strobe and pulses `wr_invalid` for one cycle, in the cycle after the request. A read there returns zero.
- R3: An aligned 4-byte write (`req_size`=2, offset mod 4 = 0) stores `req_wdata` unchanged into the selected word.
- R4: `req_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. A narrower or unaligned write stores `(cur & ~(M<<8L)) | ((wdata & M)<<8L)`, where L is offset mod 4 and M is the low 8×bytes ones. The result is truncated to 32 bits, so lanes beyond byte 3 are dropped.
- R5: A read returns `(word >> 8L) & M`, with L and M as in R4.
- R6: Each mapped write gives exactly one strobe on exactly one bank, in the cycle after the request. The strobe carries the word index and the merged data. No strobe occurs without a write request.
- R7: A request issued in the cycle directly after a write to the same word uses the value of that write as the word's current contents, for both merging and reading.
- R8: While reset is asserted and after its release, `rsp_valid`, `wr_invalid` and all write strobes are low until a request arrives.
- R9: A read request yields `rsp_valid` high with `rsp_rdata` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Byte offset in the window |
| req_size | input | 2 | Access width code (R4) |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_valid | output | 1 | Read data available |
| rsp_rdata | output | 32 | Read data, right-justified |
| wr_invalid | output | 1 | Write to unmapped offset was discarded |
| core_rd_idx | output | 4 | Core bank read index |
| core_rd_data | input | 32 | Core bank read data |
| core_wr_en | output | 1 | Core bank write strobe |
| core_wr_idx | output | 4 | Core bank write index |
| core_wr_data | output | 32 | Core bank write data |
| dma_rd_idx | output | 3 | DMA bank read index |
| dma_rd_data | input | 32 | DMA bank read data |
| dma_wr_en | output | 1 | DMA bank write strobe |
| dma_wr_idx | output | 3 | DMA bank write index |
| dma_wr_data | output | 32 | DMA bank write data |
| ctl_rd_data | input | 32 | Control word read data |
| ctl_wr_en | output | 1 | Control word write strobe |
| ctl_wr_data | output | 32 | Control word write data |

## Verification
The bench sweeps every offset with every width, once as a write and once as a read placed directly behind it. This exposes two faults. A merge that takes the wrong lane corrupts bytes that should have been kept. A design that reads the bank rather than the pending write loses the update it has just made. Every byte lane of each DMA word is written in turn and the whole word is read back. A shift in the lane arithmetic shows up there as a wrong neighbouring byte. Unaligned wide accesses at lanes 2 and 3 check the truncation. A design that wrapped or spilled into the next word would return different data or strike the wrong index. Accesses in the gaps between regions check that nothing is strobed there and that zero is returned. A decoder with a loose boundary would instead hit a real word.

// File: rtl/subword_pkg.sv
package subword_pkg;
  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_CORE = 2'd1,
    RG_DMA  = 2'd2,
    RG_CTL  = 2'd3
  } region_e;
endpackage

// File: rtl/sw_addr_decode.sv
module sw_addr_decode
  import subword_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int LANE_W     = 2,
  parameter int CORE_WORDS = 16,
  parameter int DMA_BASE   = 'h40,
  parameter int DMA_WORDS  = 8,
  parameter int CTL_OFF    = 'h70,
  parameter int IDX_W      = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [IDX_W-1:0]  idx,
  output logic [LANE_W-1:0] lane
);
  localparam int WORD_W    = ADDR_W - LANE_W;
  localparam int DMA_WORD0 = DMA_BASE >> LANE_W;
  localparam int CTL_WORD  = CTL_OFF >> LANE_W;

  logic [WORD_W-1:0] word;
  assign word = addr[ADDR_W-1:LANE_W];
  assign lane = addr[LANE_W-1:0];

  always_comb begin
    region = RG_NONE;
    idx    = '0;
    if (int'(word) < CORE_WORDS) begin
      region = RG_CORE;
      idx    = IDX_W'(word);
    end else if (int'(word) >= DMA_WORD0 && int'(word) < DMA_WORD0 + DMA_WORDS) begin
      region = RG_DMA;
      idx    = IDX_W'(int'(word) - DMA_WORD0);
    end else if (int'(word) == CTL_WORD) begin
      region = RG_CTL;
    end
  end
endmodule

// File: rtl/sw_lane_merge.sv
module sw_lane_merge #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 2
) (
  input  logic [DATA_W-1:0] cur,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANE_W-1:0] lane,
  input  logic [1:0]        size,
  output logic [DATA_W-1:0] merged,
  output logic [DATA_W-1:0] extracted
);
  localparam int BYTES = DATA_W / 8;

  int unsigned       nbytes;
  logic [DATA_W-1:0] width_mask;
  logic [DATA_W-1:0] lane_mask;

  always_comb begin
    case (size)
      2'd0:    nbytes = 1;
      2'd1:    nbytes = 2;
      default: nbytes = BYTES;
    endcase
  end

  generate
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
      assign width_mask[8*b +: 8] = (b < nbytes) ? 8'hFF : 8'h00;
    end
  endgenerate

  assign lane_mask = width_mask << (8 * lane);
  assign merged    = (cur & ~lane_mask) | ((wdata & width_mask) << (8 * lane));
  assign extracted = (cur >> (8 * lane)) & width_mask;
endmodule

// File: rtl/subword_reg_adapter.sv
module subword_reg_adapter
  import subword_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 32,
  parameter int CORE_WORDS = 16,
  parameter int DMA_BASE   = 'h40,
  parameter int DMA_WORDS  = 8,
  parameter int CTL_OFF    = 'h70,
  localparam int LANE_W    = $clog2(DATA_W / 8),
  localparam int CIDX_W    = $clog2(CORE_WORDS),
  localparam int DIDX_W    = $clog2(DMA_WORDS),
  localparam int IDX_W     = (CIDX_W > DIDX_W) ? CIDX_W : DIDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              wr_invalid,
  output logic [CIDX_W-1:0] core_rd_idx,
  input  logic [DATA_W-1:0] core_rd_data,
  output logic              core_wr_en,
  output logic [CIDX_W-1:0] core_wr_idx,
  output logic [DATA_W-1:0] core_wr_data,
  output logic [DIDX_W-1:0] dma_rd_idx,
  input  logic [DATA_W-1:0] dma_rd_data,
  output logic              dma_wr_en,
  output logic [DIDX_W-1:0] dma_wr_idx,
  output logic [DATA_W-1:0] dma_wr_data,
  input  logic [DATA_W-1:0] ctl_rd_data,
  output logic              ctl_wr_en,
  output logic [DATA_W-1:0] ctl_wr_data
);
  region_e           dec_region;
  logic [IDX_W-1:0]  dec_idx;
  logic [LANE_W-1:0] dec_lane;

  sw_addr_decode #(
    .ADDR_W(ADDR_W), .LANE_W(LANE_W), .CORE_WORDS(CORE_WORDS),
    .DMA_BASE(DMA_BASE), .DMA_WORDS(DMA_WORDS), .CTL_OFF(CTL_OFF), .IDX_W(IDX_W)
  ) u_decode (
    .addr(req_addr), .region(dec_region), .idx(dec_idx), .lane(dec_lane)
  );

  assign core_rd_idx = CIDX_W'(dec_idx);
  assign dma_rd_idx  = DIDX_W'(dec_idx);

  // Pending write stage
  logic              pend_valid_q, pend_valid_d;
  region_e           pend_region_q;
  logic [IDX_W-1:0]  pend_idx_q;
  logic [DATA_W-1:0] pend_data_q;
  logic              rsp_valid_d, wr_invalid_d;
  logic [DATA_W-1:0] rsp_rdata_d;

  logic [DATA_W-1:0] bank_word, cur_word, merged, extracted;
  logic              fwd_hit;
  logic              wr_req, rd_req, load_pend, load_rsp;

  always_comb begin
    case (dec_region)
      RG_CORE: bank_word = core_rd_data;
      RG_DMA:  bank_word = dma_rd_data;
      RG_CTL:  bank_word = ctl_rd_data;
      default: bank_word = '0;
    endcase
  end

  // R7: the pending write has not reached its bank yet
  assign fwd_hit  = pend_valid_q && (pend_region_q == dec_region) &&
                    (pend_idx_q == dec_idx) && (dec_region != RG_NONE);
  assign cur_word = fwd_hit ? pend_data_q : bank_word;

  sw_lane_merge #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_merge (
    .cur(cur_word), .wdata(req_wdata), .lane(dec_lane), .size(req_size),
    .merged(merged), .extracted(extracted)
  );

  assign wr_req    = req_valid && req_write;
  assign rd_req    = req_valid && !req_write;
  assign load_pend = wr_req && (dec_region != RG_NONE);
  assign load_rsp  = rd_req;

  always_comb begin
    pend_valid_d = load_pend;
    wr_invalid_d = wr_req && (dec_region == RG_NONE);
    rsp_valid_d  = rd_req;
    rsp_rdata_d  = (dec_region == RG_NONE) ? '0 : extracted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid_q  <= 1'b0;
      pend_region_q <= RG_NONE;
      pend_idx_q    <= '0;
      pend_data_q   <= '0;
      rsp_valid     <= 1'b0;
      rsp_rdata     <= '0;
      wr_invalid    <= 1'b0;
    end else begin
      pend_valid_q <= pend_valid_d;
      rsp_valid    <= rsp_valid_d;
      wr_invalid   <= wr_invalid_d;
      if (load_pend) begin
        pend_region_q <= dec_region;
        pend_idx_q    <= dec_idx;
        pend_data_q   <= merged;
      end
      if (load_rsp) begin
        rsp_rdata <= rsp_rdata_d;
      end
    end
  end

  assign core_wr_en   = pend_valid_q && (pend_region_q == RG_CORE);
  assign dma_wr_en    = pend_valid_q && (pend_region_q == RG_DMA);
  assign ctl_wr_en    = pend_valid_q && (pend_region_q == RG_CTL);
  assign core_wr_idx  = CIDX_W'(pend_idx_q);
  assign dma_wr_idx   = DIDX_W'(pend_idx_q);
  assign core_wr_data = pend_data_q;
  assign dma_wr_data  = pend_data_q;
  assign ctl_wr_data  = pend_data_q;

  logic any_wr;
  assign any_wr = core_wr_en || dma_wr_en || ctl_wr_en;

  a_r6_strobe_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && dec_region != RG_NONE) |=> any_wr);
  a_r6_no_spurious_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> !any_wr);
  a_r6_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({core_wr_en, dma_wr_en, ctl_wr_en}));
  a_r2_invalid_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_invalid |-> !any_wr);
  a_r2_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && dec_region == RG_NONE) |=> (rsp_rdata == '0));
  a_r9_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
endmodule

// File: tb/tb_subword_reg_adapter.sv
`timescale 1ns/1ps
module tb_subword_reg_adapter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [6:0]  req_addr;
  logic [1:0]  req_size;
  logic [31:0] req_wdata;
  logic        rsp_valid, wr_invalid;
  logic [31:0] rsp_rdata;
  logic [3:0]  core_rd_idx, core_wr_idx;
  logic [2:0]  dma_rd_idx, dma_wr_idx;
  logic        core_wr_en, dma_wr_en, ctl_wr_en;
  logic [31:0] core_wr_data, dma_wr_data, ctl_wr_data;
  logic [31:0] core_rd_data, dma_rd_data, ctl_rd_data;

  logic [31:0] bcore [16];
  logic [31:0] bdma  [8];
  logic [31:0] bctl;
  logic [31:0] mcore [16];
  logic [31:0] mdma  [8];
  logic [31:0] mctl;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  assign core_rd_data = bcore[core_rd_idx];
  assign dma_rd_data  = bdma[dma_rd_idx];
  assign ctl_rd_data  = bctl;

  always @(posedge clk) begin
    if (core_wr_en) bcore[core_wr_idx] <= core_wr_data;
    if (dma_wr_en)  bdma[dma_wr_idx]   <= dma_wr_data;
    if (ctl_wr_en)  bctl               <= ctl_wr_data;
  end

  subword_reg_adapter dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .wr_invalid(wr_invalid),
    .core_rd_idx(core_rd_idx), .core_rd_data(core_rd_data), .core_wr_en(core_wr_en),
    .core_wr_idx(core_wr_idx), .core_wr_data(core_wr_data),
    .dma_rd_idx(dma_rd_idx), .dma_rd_data(dma_rd_data), .dma_wr_en(dma_wr_en),
    .dma_wr_idx(dma_wr_idx), .dma_wr_data(dma_wr_data),
    .ctl_rd_data(ctl_rd_data), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] wmask(input int sz);
    if (sz == 0) return 32'h0000_00FF;
    if (sz == 1) return 32'h0000_FFFF;
    return 32'hFFFF_FFFF;
  endfunction

  // region: 0 none, 1 core, 2 dma, 3 ctl
  function automatic int region_of(input int a);
    if (a < 'h40) return 1;
    if (a < 'h60) return 2;
    if (a >= 'h70 && a < 'h74) return 3;
    return 0;
  endfunction

  function automatic logic [31:0] model_get(input int a);
    case (region_of(a))
      1: return mcore[a >> 2];
      2: return mdma[(a - 'h40) >> 2];
      3: return mctl;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_put(input int a, input logic [31:0] v);
    case (region_of(a))
      1: mcore[a >> 2] = v;
      2: mdma[(a - 'h40) >> 2] = v;
      3: mctl = v;
      default: ;
    endcase
  endtask

  // Drives one request for one cycle and checks the result in the next.
  task automatic access(input bit wr, input int a, input int sz, input logic [31:0] wd, input string req);
    logic [31:0] m, cur, exp;
    int lane, reg_id;
    lane   = a % 4;
    reg_id = region_of(a);
    m      = wmask(sz);
    cur    = model_get(a);
    if (wr) begin
      exp = (cur & ~(m << (8 * lane))) | ((wd & m) << (8 * lane));
      model_put(a, exp);
    end else begin
      exp = (cur >> (8 * lane)) & m;
    end
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = 7'(a);
    req_size  = 2'(sz);
    req_wdata = wd;
    @(negedge clk);
    if (wr) begin
      if (reg_id == 0) begin
        chk(wr_invalid && !core_wr_en && !dma_wr_en && !ctl_wr_en, {req, " R2 unmapped write"},
            {29'd0, core_wr_en, dma_wr_en, ctl_wr_en}, 32'h0);
      end else begin
        chk((core_wr_en == (reg_id == 1)) && (dma_wr_en == (reg_id == 2)) &&
            (ctl_wr_en == (reg_id == 3)) && !wr_invalid, {req, " R6 strobe"},
            {29'd0, core_wr_en, dma_wr_en, ctl_wr_en}, 32'(reg_id));
        if (reg_id == 1) begin
          chk(core_wr_idx == 4'(a >> 2), {req, " R1 core index"}, 32'(core_wr_idx), 32'(a >> 2));
          chk(core_wr_data == exp, {req, " R4 core data"}, core_wr_data, exp);
        end else if (reg_id == 2) begin
          chk(dma_wr_idx == 3'((a - 'h40) >> 2), {req, " R1 dma index"}, 32'(dma_wr_idx), 32'((a - 'h40) >> 2));
          chk(dma_wr_data == exp, {req, " R4 dma data"}, dma_wr_data, exp);
        end else begin
          chk(ctl_wr_data == exp, {req, " R4 ctl data"}, ctl_wr_data, exp);
        end
      end
    end else begin
      chk(rsp_valid && !wr_invalid, {req, " R9 rsp_valid"}, {31'd0, rsp_valid}, 32'h1);
      chk(rsp_rdata == exp, {req, " R5 read data"}, rsp_rdata, exp);
    end
  endtask

  task automatic idle();
    req_valid = 1'b0;
    req_write = 1'b0;
    @(negedge clk);
    chk(!core_wr_en && !dma_wr_en && !ctl_wr_en && !rsp_valid && !wr_invalid, "R6 idle quiet",
        {28'd0, core_wr_en, dma_wr_en, ctl_wr_en, rsp_valid}, 32'h0);
  endtask

  initial begin : watchdog
    #(5.0 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      bcore[i] = 32'h1000_0000 + i * 32'h0102_0304;
      mcore[i] = bcore[i];
    end
    for (int i = 0; i < 8; i++) begin
      bdma[i] = 32'hD000_0000 ^ (i * 32'h1111_1111);
      mdma[i] = bdma[i];
    end
    bctl = 32'hC0DE_F00D;
    mctl = bctl;
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_size = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(!rsp_valid && !wr_invalid && !core_wr_en && !dma_wr_en && !ctl_wr_en, "R8 in reset",
        {27'd0, rsp_valid, wr_invalid, core_wr_en, dma_wr_en, ctl_wr_en}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && !wr_invalid && !core_wr_en && !dma_wr_en && !ctl_wr_en, "R8 after release",
        {27'd0, rsp_valid, wr_invalid, core_wr_en, dma_wr_en, ctl_wr_en}, 32'h0);

    // R1 R2 R5: full-word read of every word slot, mapped or not
    for (int a = 0; a < 128; a += 4) access(1'b0, a, 2, 32'h0, "R1");
    idle();

    // R3: aligned full writes everywhere
    for (int a = 0; a < 128; a += 4) access(1'b1, a, 2, 32'h5A00_0000 + a * 32'h0001_0203, "R3");
    idle();

    // R4: each byte lane of each DMA word, then full readback
    for (int i = 0; i < 8; i++) begin
      for (int l = 0; l < 4; l++) begin
        access(1'b1, 'h40 + 4 * i + l, 0, 32'hFFFF_FF00 | (8'h30 + 8'(i * 4 + l)), "R4 dma lane");
        idle();
        access(1'b0, 'h40 + 4 * i, 2, 32'h0, "R4 dma keep");
        idle();
      end
    end

    // R7: back-to-back writes to the same word, then read behind them
    access(1'b1, 'h08, 0, 32'h0000_00AA, "R7 first");
    access(1'b1, 'h09, 0, 32'h0000_00BB, "R7 second");
    access(1'b1, 'h72, 1, 32'h0000_1234, "R7 ctl");
    access(1'b0, 'h70, 2, 32'h0, "R7 ctl read");
    access(1'b0, 'h08, 2, 32'h0, "R7 read");
    idle();

    // R4 R5 R7: every offset and width, write then read back-to-back
    for (int a = 0; a < 128; a++) begin
      for (int sz = 0; sz < 3; sz++) begin
        access(1'b1, a, sz, 32'h9E37_79B9 * (a * 3 + sz + 1), "R4 sweep");
        access(1'b0, a, sz, 32'h0, "R7 sweep");
      end
    end
    idle();

    // R3 R6: bank contents equal model, so each write landed once where intended
    for (int i = 0; i < 16; i++) chk(bcore[i] == mcore[i], "R6 core bank", bcore[i], mcore[i]);
    for (int i = 0; i < 8; i++)  chk(bdma[i] == mdma[i], "R6 dma bank", bdma[i], mdma[i]);
    chk(bctl == mctl, "R6 ctl word", bctl, mctl);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule